// File: doc/BRIEF.md
# Four-Source Interrupt Register Bank

This block is the interrupt front end of a serial port. Four event inputs report transmit-watermark, receive-watermark, transmit-empty and receive-overflow conditions as one-cycle pulses. Each pulse sets a sticky bit in a pending register. Software sees the pending bits and a mask register on a plain 32-bit, word-addressed register port. It clears pending bits by writing ones to them, and it can raise them on purpose through a write-only force register. Each of the four interrupt lines is a level signal: pending AND mask.

The block has no sequential controller. Its one enumerated type, `reg_sel_e`, names the register that the current address selects. `SEL_STATE` selects the pending register, `SEL_ENABLE` the mask, `SEL_TEST` the force register, and `SEL_NONE` any other word. The selection is worked out again from the address on every cycle. There are no transitions between these values and no history. A write takes effect at the rising clock edge where `bus_wr` is high. Reads are combinational and have no side effects.

Top module: `irq_bank`

## Requirements
- R1: After reset the pending register and the mask register read as 0, and all four interrupt lines are low.
- R2: The address word `bus_addr[7:2]` selects the register: 0 is pending, 1 is mask, 2 is force. Address bits [1:0] are ignored. Source n uses bit n of every register and of `hw_event` and `irq_out`: 0 is transmit watermark, 1 is receive watermark, 2 is transmit empty, 3 is receive overflow.
- R3: A one-cycle pulse on `hw_event[n]` sets pending bit n. The bit stays set after the pulse ends.
- R4: A write to the pending register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: A write to the force register sets each pending bit written as 1 and leaves the others unchanged.
- R6: A read of the force register returns 0, whatever the pending state is.
- R7: `irq_out[n]` is high exactly when pending bit n and mask bit n are both 1. It follows any change to either register from the clock edge that makes the change.
- R8: When an event pulse and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R9: A read of any word other than 0, 1 or 2 returns 0. A write to such a word changes neither register.
- R10: A write to the mask register stores bits [3:0] of the write data. Bits [31:4] of every read are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| hw_event | input | 4 | Event pulses from the serial datapath |
| irq_out | output | 4 | Level interrupt per source |

## Verification
The hardest case to reach from the ports is a software clear and a hardware event landing on the same pending bit in the same clock cycle. In normal use they are separated by the software latency. The bench drives the write strobe and an event pulse in the same half cycle, so both are sampled at one edge. It then reads the pending register back to confirm that the colliding bit stayed set while the bits that were only cleared went to 0. Beyond that case, the bench sweeps every pending/mask pair and every pending/clear-mask pair, and compares the interrupt lines and read data with values computed bitwise.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    // Register selected by the current bus address
    typedef enum logic [1:0] {
        SEL_STATE  = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_TEST   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Word indices (address >> 2) of the mapped registers
    localparam int unsigned WORD_STATE     = 0;
    localparam int unsigned WORD_ENABLE    = 1;
    localparam int unsigned WORD_TEST      = 2;
    localparam int unsigned BYTE_LANE_BITS = 2;

endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int WORD_W = ADDR_W - BYTE_LANE_BITS;

    logic [WORD_W-1:0] word;
    logic              unused_lane;

    assign word        = addr[ADDR_W-1:BYTE_LANE_BITS];
    assign unused_lane = ^addr[BYTE_LANE_BITS-1:0];

    always_comb begin
        unique case (word)
            WORD_W'(WORD_STATE):  sel = SEL_STATE;
            WORD_W'(WORD_ENABLE): sel = SEL_ENABLE;
            WORD_W'(WORD_TEST):   sel = SEL_TEST;
            default:              sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/irq_bank_sticky.sv
module irq_bank_sticky #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_hw,
    input  logic [NUM_SRC-1:0] set_sw,
    input  logic [NUM_SRC-1:0] clr_sw,
    output logic [NUM_SRC-1:0] state
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (set_hw[i] || set_sw[i]) begin
                bit_q <= 1'b1;       // any set beats a clear
            end else if (clr_sw[i]) begin
                bit_q <= 1'b0;
            end
        end
        assign state[i] = bit_q;
    end
endmodule

// File: rtl/irq_bank_rdmux.sv
module irq_bank_rdmux
    import irq_bank_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int DATA_W  = 32
) (
    input  reg_sel_e           sel,
    input  logic [NUM_SRC-1:0] state,
    input  logic [NUM_SRC-1:0] enable,
    output logic [DATA_W-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_STATE:  rdata[NUM_SRC-1:0] = state;
            SEL_ENABLE: rdata[NUM_SRC-1:0] = enable;
            SEL_TEST:   rdata = '0;
            SEL_NONE:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irq_bank_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] hw_event,
    output logic [NUM_SRC-1:0] irq_out
);
    reg_sel_e           sel;
    logic [NUM_SRC-1:0] wmask;
    logic [NUM_SRC-1:0] clr_sw;
    logic [NUM_SRC-1:0] set_sw;
    logic [NUM_SRC-1:0] state_q;
    logic [NUM_SRC-1:0] enable_q;
    logic               unused_hi;

    assign wmask     = bus_wdata[NUM_SRC-1:0];
    assign unused_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

    irq_bank_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign clr_sw = (bus_wr && sel == SEL_STATE) ? wmask : '0;
    assign set_sw = (bus_wr && sel == SEL_TEST)  ? wmask : '0;

    irq_bank_sticky #(.NUM_SRC(NUM_SRC)) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_hw (hw_event),
        .set_sw (set_sw),
        .clr_sw (clr_sw),
        .state  (state_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (bus_wr && sel == SEL_ENABLE) begin
            enable_q <= wmask;
        end
    end

    irq_bank_rdmux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rdmux (
        .sel    (sel),
        .state  (state_q),
        .enable (enable_q),
        .rdata  (bus_rdata)
    );

    assign irq_out = state_q & enable_q;
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
    parameter int NUM_SRC = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_SRC-1:0] hw_event,
    input logic [NUM_SRC-1:0] irq_out,
    input logic [NUM_SRC-1:0] state_q
);
    logic [ADDR_W-3:0] word;
    assign word = bus_addr[ADDR_W-1:2];

    // R3 R8
    event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_event != '0) |=> ((state_q & $past(hw_event)) == $past(hw_event)));

    // R4
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && word == '0 && hw_event == '0)
        |=> (state_q == ($past(state_q) & ~$past(bus_wdata[NUM_SRC-1:0]))));

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && hw_event == '0) |=> $stable(irq_out));

    // R6 R9
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word != '0 && word != (ADDR_W-2)'(1)) |-> (bus_rdata == '0));

    // R10
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_SRC] == '0);
endmodule

bind irq_bank irq_bank_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .hw_event  (hw_event),
    .irq_out   (irq_out),
    .state_q   (state_q)
);

// File: tb/irq_bank_bench.sv
module irq_bank_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  hw_event = '0;
    logic [3:0]  irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_bank u_irq_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hw_event  (hw_event),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_wr   = 1'b0;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); check("R1 pending", v, 0);
        rd(8'h04, v); check("R1 mask", v, 0);
        check("R1 irq", {28'd0, irq_out}, 0);

        // R5 R7 R10 full pending x mask sweep, upper write bits set
        for (int e = 0; e < 16; e++) begin
            for (int s = 0; s < 16; s++) begin
                wr(8'h00, 32'hFFFF_FFFF);
                wr(8'h08, 32'hABCD_0000 | s);
                wr(8'h04, 32'h1234_5670 | e);
                check("R7 irq", {28'd0, irq_out}, s & e);
                rd(8'h00, v); check("R5 pending", v, s);
                rd(8'h04, v); check("R10 mask", v, e);
            end
        end

        // R4 clear sweep
        wr(8'h04, 32'hF);
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                wr(8'h00, 32'hF);
                wr(8'h08, s);
                wr(8'h00, c);
                rd(8'h00, v); check("R4 w1c", v, s & ~c & 32'hF);
                check("R7 irq after clear", {28'd0, irq_out}, s & ~c & 32'hF);
            end
        end

        // R3 event pulses, sticky and accumulating
        wr(8'h00, 32'hF);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            hw_event = 4'(1 << i);
            @(negedge clk);
            hw_event = '0;
            @(negedge clk);
            rd(8'h00, v); check("R3 sticky", v, (2 << i) - 1);
            check("R7 irq from event", {28'd0, irq_out}, (2 << i) - 1);
        end

        // R8 set beats clear in same cycle
        @(negedge clk);
        bus_addr = 8'h00; bus_wdata = 32'hF; bus_wr = 1'b1; hw_event = 4'b0100;
        @(negedge clk);
        bus_wr = 1'b0; hw_event = '0;
        rd(8'h00, v); check("R8 set wins", v, 32'h4);

        // R6 force register reads zero with pending set
        wr(8'h08, 32'hF);
        rd(8'h08, v); check("R6 force read", v, 0);

        // R2 low address bits ignored
        wr(8'h07, 32'h5);
        rd(8'h04, v); check("R2 alias write", v, 5);
        rd(8'h06, v); check("R2 alias read", v, 5);
        wr(8'h03, 32'h3);
        rd(8'h01, v); check("R2 alias clear", v, 32'hC);

        // R9 unmapped words
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R9 pending kept", v, 32'hC);
        rd(8'h04, v); check("R9 mask kept", v, 5);
        rd(8'h0C, v); check("R9 read zero", v, 0);
        rd(8'hF0, v); check("R9 read zero high", v, 0);
        check("R7 irq final", {28'd0, irq_out}, 32'h4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule